// File: doc/BRIEF.md
# Register-Mapped SPI Transaction Engine

A single-select SPI master driven through a small bank of 32-bit registers. Software loads up to eight outgoing bytes into two data words, writes a transmit and a receive byte count, and then issues a start command. One start runs a complete half-duplex exchange: the transmit bytes go out first, the requested receive bytes are clocked in straight after, and the received bytes are written back into the same two data words. A busy flag in the control word shows when the exchange is running.

Chip select does not follow the transactions. It follows one software-owned bit, so a command and the data phases that come after it can share one select window across several starts. The serial clock comes from the system clock through a programmable divider. The divider value is captured when a start is accepted.

Top module: `spi_txn_engine`

## Requirements
- R1: After reset every register reads 0, `cs_no` is 1, and `sclk_o` and `mosi_o` are 0.
- R2: The control word (offset 0x00) reads the transmit count in bits 3:0, the receive count in bits 7:4 and busy in bit 16. The start bit (bit 8) and all other bits always read 0.
- R3: A transaction begins only when a write to 0x00 has bit 8 set while busy is 0, the transmit count is 1..8 and the receive count is 0..8. A write with bit 8 clear stores the counts without starting. A start with counts outside those ranges stores the counts but produces no serial clock and leaves busy at 0.
- R4: Transmit bytes are sent in index order 0..7, MSB first, in SPI mode 0 (clock idles low, `mosi_o` stable while `sclk_o` is high). Byte 0 is word A (0x04) bits 7:0, byte 1 is A[31:24], byte 2 is A[23:16], byte 3 is A[15:8], and bytes 4..7 are word B (0x08) bits 7:0, 15:8, 23:16, 31:24.
- R5: Receive bits start on the serial clock period that follows the last transmit bit, with no gap. `miso_i` is sampled on each rising edge, MSB first. `mosi_o` is 0 during the receive phase.
- R6: At the end of a transaction, receive byte k (k<4) is written to word B bits 8k+7:8k, and byte k (k≥4) to word A bits 8(k-4)+7:8(k-4). Byte lanes at or beyond the receive count keep their contents, so a receive count of 0 changes neither word.
- R7: Busy reads 1 from the edge that accepts a start for exactly (tx+rx)·8·(D+2) system cycles, where D is the captured divider value.
- R8: One serial bit lasts D+2 system cycles. `sclk_o` is low for the first (D+2)−⌊(D+2)/2⌋ cycles of the bit and high for the rest, so D=3 divides the system clock by 5. Changing the divider while busy does not affect the running transaction.
- R9: While busy is 1, writes to word A, word B and the control word are ignored.
- R10: `cs_no` is low exactly while bit 0 of the select register (0x38) is 1, independent of transactions. The bit reads back, and the other bits of that register read 0.
- R11: The configuration register (0x28) stores a divider in bits 27:16 and a 3-bit field in bits 31:29. Both read back, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
On every cycle the assertions check the following. The bit counter stays inside the transaction length, the divider phase stays inside the captured period, and a start is only ever seen while the engine is idle. Each accepted start sets busy, and the completion strobe clears it. `mosi_o` holds while the serial clock is high, and words A and B and the counts stay frozen while busy. Some behaviours only the bench scenarios can show: the byte-lane order on the wire and in write-back, the lanes left untouched by short reads, the exact busy length, the high and low split of the clock for odd and even periods, and the rejection of out-of-range counts. The bench shows these by comparing every cycle against a behavioural model and a serial slave.

// File: rtl/ste_pkg.sv
package ste_pkg;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned DIV_W     = 12;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned MAX_BYTES = 8;
  localparam int unsigned STREAM_W  = MAX_BYTES * 8;
  localparam int unsigned HALF_B    = MAX_BYTES / 2;
  localparam int unsigned IDX_W     = $clog2(2 * STREAM_W + 1);

  localparam int unsigned START_BIT = 8;
  localparam int unsigned DIV_LSB   = 16;
  localparam int unsigned MODE_LSB  = 29;

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

  localparam logic [ADDR_W-1:0] A_XFER = 6'h00;
  localparam logic [ADDR_W-1:0] A_WRDA = 6'h04;
  localparam logic [ADDR_W-1:0] A_WRDB = 6'h08;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h28;
  localparam logic [ADDR_W-1:0] A_SEL  = 6'h38;
endpackage

// File: rtl/ste_regs.sv
module ste_regs
  import ste_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                busy_i,
  input  logic                done_i,
  input  logic [STREAM_W-1:0] rx_sr_i,
  output logic                start_o,
  output logic [CNT_W-1:0]    go_tx_o,
  output logic [CNT_W-1:0]    go_rx_o,
  output logic [STREAM_W-1:0] tx_stream_o,
  output logic [DIV_W-1:0]    run_div_o,
  output logic                sel_o
);
  logic [DATA_W-1:0] wa_q, wb_q;
  logic [CNT_W-1:0]  txn_q, rxn_q;
  logic [DIV_W-1:0]  div_q, run_div_q;
  logic [MODE_W-1:0] mode_q;
  logic              sel_q;

  logic wr, wr_xfer, wr_a, wr_b, cnt_ok;
  logic [CNT_W-1:0] w_tx, w_rx;
  logic       rx_we   [MAX_BYTES];
  logic [7:0] rx_byte [MAX_BYTES];

  function automatic logic [7:0] rx_pick(input logic [STREAM_W-1:0] sr,
                                         input logic [CNT_W-1:0] sel);
    return sr[8*sel +: 8];
  endfunction

  assign wr      = req_i & we_i;
  assign wr_xfer = wr & (addr_i == A_XFER) & ~busy_i;
  assign wr_a    = wr & (addr_i == A_WRDA) & ~busy_i;
  assign wr_b    = wr & (addr_i == A_WRDB) & ~busy_i;
  assign w_tx    = wdata_i[CNT_W-1:0];
  assign w_rx    = wdata_i[2*CNT_W-1:CNT_W];
  assign cnt_ok  = (w_tx != '0) && (w_tx <= MAX_CNT) && (w_rx <= MAX_CNT);
  assign start_o = wr_xfer & wdata_i[START_BIT] & cnt_ok;
  assign go_tx_o = w_tx;
  assign go_rx_o = w_rx;

  // wire order: A[7:0], A[31:24], A[23:16], A[15:8], then B low to high
  assign tx_stream_o = {wa_q[7:0], wa_q[31:24], wa_q[23:16], wa_q[15:8],
                        wb_q[7:0], wb_q[15:8], wb_q[23:16], wb_q[31:24]};

  // last received byte sits at the bottom of the shift register
  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++) begin
      rx_we[k]   = done_i && (CNT_W'(k) < rxn_q);
      rx_byte[k] = rx_pick(rx_sr_i, rx_we[k] ? rxn_q - CNT_W'(k + 1) : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_q      <= '0;
      wb_q      <= '0;
      txn_q     <= '0;
      rxn_q     <= '0;
      div_q     <= '0;
      run_div_q <= '0;
      mode_q    <= '0;
      sel_q     <= 1'b0;
    end else begin
      if (wr_xfer) begin
        txn_q <= w_tx;
        rxn_q <= w_rx;
      end
      if (start_o) run_div_q <= div_q;
      if (wr && addr_i == A_CFG) begin
        div_q  <= wdata_i[DIV_LSB +: DIV_W];
        mode_q <= wdata_i[MODE_LSB +: MODE_W];
      end
      if (wr && addr_i == A_SEL) sel_q <= wdata_i[0];
      if (wr_a) wa_q <= wdata_i;
      if (wr_b) wb_q <= wdata_i;
      for (int k = 0; k < HALF_B; k++) begin
        if (rx_we[k])          wb_q[8*k +: 8] <= rx_byte[k];
        if (rx_we[k + HALF_B]) wa_q[8*k +: 8] <= rx_byte[k + HALF_B];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_XFER: rdata_o = {15'd0, busy_i, 7'd0, 1'b0, rxn_q, txn_q};
      A_WRDA: rdata_o = wa_q;
      A_WRDB: rdata_o = wb_q;
      A_CFG:  rdata_o = {mode_q, 1'b0, div_q, 16'd0};
      A_SEL:  rdata_o = {31'd0, sel_q};
      default: rdata_o = '0;
    endcase
  end

  assign run_div_o = run_div_q;
  assign sel_o     = sel_q;

  p_words_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> $stable(wa_q) && $stable(wb_q));
  p_counts_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(txn_q) && $stable(rxn_q));
  p_start_counts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (txn_q != '0) && (txn_q <= MAX_CNT) && (rxn_q <= MAX_CNT));
endmodule

// File: rtl/ste_clkdiv.sv
module ste_clkdiv
  import ste_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_o,
  output logic             bit_end_o,
  output logic             sclk_o
);
  localparam int unsigned PW = DIV_W + 1;

  logic [PW-1:0] period, low_len, cnt_q;

  assign period    = PW'(div_i) + PW'(2);
  assign low_len   = period - (period >> 1);
  assign rise_o    = run_i && (cnt_q == low_len - PW'(1));
  assign bit_end_o = run_i && (cnt_q == period - PW'(1));
  assign sclk_o    = run_i && (cnt_q >= low_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + PW'(1);
  end

  p_phase_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < period);
endmodule

// File: rtl/ste_shift.sv
module ste_shift
  import ste_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    go_tx_i,
  input  logic [CNT_W-1:0]    go_rx_i,
  input  logic [STREAM_W-1:0] tx_stream_i,
  input  logic                rise_i,
  input  logic                bit_end_i,
  input  logic                miso_i,
  output logic                busy_o,
  output logic                mosi_o,
  output logic                done_o,
  output logic [STREAM_W-1:0] rx_sr_o
);
  logic                busy_q;
  logic [IDX_W-1:0]    idx_q, tot_q, txb_q;
  logic [STREAM_W-1:0] tx_sr_q, rx_sr_q;
  logic                in_tx, last;

  assign in_tx  = idx_q < txb_q;
  assign last   = idx_q == tot_q - IDX_W'(1);
  assign done_o = busy_q & bit_end_i & last;
  assign mosi_o = busy_q & in_tx & tx_sr_q[STREAM_W-1];
  assign busy_o = busy_q;
  assign rx_sr_o = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      tot_q   <= '0;
      txb_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      tot_q   <= (IDX_W'(go_tx_i) + IDX_W'(go_rx_i)) << 3;
      txb_q   <= IDX_W'(go_tx_i) << 3;
      tx_sr_q <= tx_stream_i;
      rx_sr_q <= '0;
    end else if (busy_q) begin
      if (rise_i && !in_tx) rx_sr_q <= {rx_sr_q[STREAM_W-2:0], miso_i};
      if (bit_end_i) begin
        if (last) busy_q <= 1'b0;
        else begin
          idx_q <= idx_q + IDX_W'(1);
          if (in_tx) tx_sr_q <= tx_sr_q << 1;
        end
      end
    end
  end

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q < tot_q);
  p_done_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import ste_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic                start, busy, done, rise, bit_end, sel;
  logic [CNT_W-1:0]    go_tx, go_rx;
  logic [STREAM_W-1:0] tx_stream, rx_sr;
  logic [DIV_W-1:0]    run_div;

  ste_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_sr_i(rx_sr),
    .start_o(start), .go_tx_o(go_tx), .go_rx_o(go_rx),
    .tx_stream_o(tx_stream), .run_div_o(run_div), .sel_o(sel)
  );

  ste_clkdiv u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_i(run_div),
    .rise_o(rise), .bit_end_o(bit_end), .sclk_o(sclk_o)
  );

  ste_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .go_tx_i(go_tx), .go_rx_i(go_rx),
    .tx_stream_i(tx_stream), .rise_i(rise), .bit_end_i(bit_end),
    .miso_i, .busy_o(busy), .mosi_o(mosi_o), .done_o(done), .rx_sr_o(rx_sr)
  );

  assign cs_no = ~sel;

  p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));
endmodule

// File: tb/spi_txn_engine_test.sv
module spi_txn_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, miso = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n;

  spi_txn_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // behavioural model
  bit          m_busy = 0, m_pol = 0;
  int          m_t = 0, m_p = 2, m_nb = 0, m_txb = 0, m_rxn = 0, m_div = 0;
  logic [31:0] m_a = 0, m_b = 0;
  logic [63:0] m_stream = 0, rx_pat = 0;
  int          wave_err = 0;
  string       wave_msg = "";
  logic [127:0] cap_bits = 0;
  int          cap_n = 0;
  bit          prev_sclk = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        m_t++;
        if (m_t == m_nb * 8 * m_p) begin
          m_busy = 0;
          for (int k = 0; k < m_rxn; k++) begin
            if (k < 4) m_b[8*k +: 8] = rx_pat[63-8*k -: 8];
            else       m_a[8*(k-4) +: 8] = rx_pat[63-8*k -: 8];
          end
        end
      end else if (req && we) begin
        if (addr == 6'h00 && wdata[8] && wdata[3:0] >= 1 && wdata[3:0] <= 8 && wdata[7:4] <= 8) begin
          m_busy = 1; m_t = 0; m_p = m_div + 2;
          m_nb = int'(wdata[3:0]) + int'(wdata[7:4]);
          m_txb = 8 * int'(wdata[3:0]); m_rxn = int'(wdata[7:4]);
          m_stream = {m_a[7:0], m_a[31:24], m_a[23:16], m_a[15:8],
                      m_b[7:0], m_b[15:8], m_b[23:16], m_b[31:24]};
        end
        if (addr == 6'h04) m_a = wdata;
        if (addr == 6'h08) m_b = wdata;
      end
      if (req && we && addr == 6'h28) m_div = int'(wdata[27:16]);
      if (req && we && addr == 6'h38) m_pol = wdata[0];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ph, bt;
      bit e_sclk, e_mosi;
      ph = m_t % m_p;
      bt = m_t / m_p;
      e_sclk = m_busy && (ph >= m_p - m_p / 2);
      e_mosi = (m_busy && bt < m_txb) ? m_stream[63-bt] : 1'b0;
      if (sclk !== e_sclk || mosi !== e_mosi || cs_n !== !m_pol) begin
        if (wave_err == 0)
          $sformat(wave_msg, "t=%0d sclk=%b/%b mosi=%b/%b cs_n=%b/%b",
                   m_t, sclk, e_sclk, mosi, e_mosi, cs_n, !m_pol);
        wave_err++;
      end
      if (sclk && !prev_sclk) begin
        cap_bits = {cap_bits[126:0], mosi};
        cap_n++;
      end
      prev_sclk = sclk;
      miso = (m_busy && bt >= m_txb && bt < m_nb * 8) ? rx_pat[63-(bt-m_txb)] : 1'b0;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_wave();
    wave_err = 0; cap_n = 0; cap_bits = 0;
  endtask

  task automatic wave_chk(input string tag);
    if (wave_err != 0) $display("  first mismatch %s", wave_msg);
    chk(wave_err == 0, tag, 64'(wave_err), 64'd0);
  endtask

  // poke: 0 none, 1 data/control writes while busy, 2 divider write while busy
  task automatic do_xfer(input int tx, input int rx, input int poke);
    logic [31:0] d;
    logic [63:0] exp_tx, got_tx;
    int n, lim, p_run;
    clear_wave();
    wr(6'h00, 32'(rx * 16 + tx));
    wr(6'h00, 32'(256 + rx * 16 + tx));
    p_run = m_p;
    if (poke == 1) begin
      wr(6'h04, 32'hDEADBEEF);
      wr(6'h08, 32'hCAFEF00D);
      wr(6'h00, 32'h0000_0137);
    end else if (poke == 2) begin
      wr(6'h28, 32'h0007_0000);
    end
    n = 0; lim = 0;
    do begin
      rd(6'h00, d);
      if (d[16]) n++;
      lim++;
    end while (d[16] && lim < 5000);
    if (poke == 0)
      chk(n == (tx + rx) * 8 * p_run - 1, "R7 busy length", 64'(n), 64'((tx + rx) * 8 * p_run - 1));
    wave_chk("R4 R5 R8 waveform vs model");
    chk(cap_n == (tx + rx) * 8, "R8 serial clock rising edges", 64'(cap_n), 64'((tx + rx) * 8));
    exp_tx = m_stream >> (64 - 8 * tx);
    got_tx = 64'(cap_bits >> (8 * rx)) & ((tx == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * tx)) - 1));
    chk(got_tx == exp_tx, "R4 transmit bits", got_tx, exp_tx);
  endtask

  task automatic chk_words(input string tag);
    logic [31:0] a, b;
    rd(6'h04, a);
    rd(6'h08, b);
    chk(a == m_a && b == m_b, tag, {a, b}, {m_a, m_b});
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          fails++;
          $display("FAIL watchdog expired");
          $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [31:0] d;
    logic [63:0] got;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 pins in reset", {cs_n, sclk, mosi}, 3'b100);
    rst_n = 1;
    // R1 reset values of all registers
    rd(6'h00, d); chk(d == 0, "R1 control reset", d, 0);
    rd(6'h04, d); chk(d == 0, "R1 word A reset", d, 0);
    rd(6'h08, d); chk(d == 0, "R1 word B reset", d, 0);
    rd(6'h28, d); chk(d == 0, "R1 config reset", d, 0);
    rd(6'h38, d); chk(d == 0, "R1 select reset", d, 0);

    // R11 configuration fields
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, d); chk(d == 32'hEFFF_0000, "R11 config all ones", d, 32'hEFFF_0000);
    wr(6'h28, 32'hE003_0000);
    rd(6'h28, d); chk(d == 32'hE003_0000, "R11 config divider 3", d, 32'hE003_0000);

    // R10 select
    wr(6'h38, 32'hFFFF_FFFF);
    #1 chk(cs_n == 1'b0, "R10 select asserted", cs_n, 0);
    rd(6'h38, d); chk(d == 1, "R10 select readback", d, 1);

    // R2/R3 counts without start
    wr(6'h04, 32'h1122_3344);
    wr(6'h08, 32'h5566_7788);
    clear_wave();
    wr(6'h00, 32'h0000_0008);
    repeat (20) @(negedge clk);
    rd(6'h00, d); chk(d == 32'h8, "R2 R3 counts stored, no start", d, 32'h8);
    wave_chk("R3 no clock without start");

    // R4 full transmit, divide by 5, no receive
    do_xfer(8, 0, 0);
    got = cap_bits[63:0];
    chk(got == 64'h4411_2233_8877_6655, "R4 byte lane order", got, 64'h4411_2233_8877_6655);
    chk_words("R6 receive count 0 leaves words");
    rd(6'h00, d); chk(d == 32'h8, "R2 start reads 0 after run", d, 32'h8);

    // R9 writes while busy, R6 partial write-back
    rx_pat = 64'hA5C3_0000_0000_0000;
    do_xfer(1, 2, 1);
    rd(6'h04, d); chk(d == 32'h1122_3344, "R9 word A unchanged", d, 32'h1122_3344);
    rd(6'h08, d); chk(d == 32'h5566_C3A5, "R6 R9 word B lanes", d, 32'h5566_C3A5);
    rd(6'h00, d); chk(d == 32'h21, "R9 counts unchanged", d, 32'h21);

    // R8 divider 0 (period 2)
    wr(6'h28, 32'h0000_0000);
    rx_pat = 64'h0102_0304_0506_0708;
    do_xfer(3, 5, 0);
    rd(6'h08, d); chk(d == 32'h0403_0201, "R6 word B receive bytes 0-3", d, 32'h0403_0201);
    rd(6'h04, d); chk(d == 32'h1122_3305, "R6 word A receive byte 4", d, 32'h1122_3305);

    // R8 odd period 7
    wr(6'h28, 32'h0005_0000);
    rx_pat = 64'hF00F_AA55_0000_0000;
    do_xfer(2, 3, 0);
    chk_words("R6 three byte read");

    // R5 R6 full eight plus eight
    wr(6'h28, 32'h0001_0000);
    wr(6'h04, 32'h8899_AABB);
    wr(6'h08, 32'hCCDD_EEFF);
    rx_pat = 64'h0123_4567_89AB_CDEF;
    do_xfer(8, 8, 0);
    rd(6'h08, d); chk(d == 32'h6745_2301, "R6 word B full read", d, 32'h6745_2301);
    rd(6'h04, d); chk(d == 32'hEFCD_AB89, "R6 word A full read", d, 32'hEFCD_AB89);

    // R8 divider change during busy
    wr(6'h28, 32'h0002_0000);
    rx_pat = 64'h3C00_0000_0000_0000;
    do_xfer(2, 1, 2);
    chk_words("R8 words after divider change");

    // R3 rejected starts
    clear_wave();
    wr(6'h00, 32'h0000_0110);
    rd(6'h00, d); chk(d == 32'h10, "R3 tx count 0 rejected", d, 32'h10);
    wr(6'h00, 32'h0000_0191);
    rd(6'h00, d); chk(d == 32'h91, "R3 rx count 9 rejected", d, 32'h91);
    wr(6'h00, 32'h0000_0109);
    repeat (30) @(negedge clk);
    rd(6'h00, d); chk(d == 32'h09, "R3 tx count 9 rejected", d, 32'h09);
    wave_chk("R3 no clock on rejected start");

    // R10 select off across a transaction
    wr(6'h38, 32'h0000_0000);
    #1 chk(cs_n == 1'b1, "R10 select released", cs_n, 1);
    rx_pat = 64'h7E00_0000_0000_0000;
    do_xfer(1, 1, 0);
    #1 chk(cs_n == 1'b1, "R10 select stays released", cs_n, 1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule